// File: doc/BRIEF.md
# Hybrid Self-Test Session Sequencer

This block runs a combined pseudorandom and stored-pattern self-test over several embedded cores. Each core owns a local pattern generator that the sequencer enables for a programmed number of cycles. After that, the core needs a series of stored patterns fetched from one shared pattern memory and driven over one shared test bus. All generators start together on a start pulse. The stored-pattern phases are serialized on the bus, so a core may sit idle until the bus is free.

For each core the integrator programs a pseudorandom length, a stored-pattern count, a cycles-per-pattern pacing value and a base address. These inputs are held stable while a test runs. The sequencer reports a done flag per core and a global done flag. It also reports the measured total test length in clock cycles, which a test flow can compare against the planned schedule.

Top module: `hbist_seq`

## Requirements
- R1: While rst_ni is low and after its release, with no start accepted yet, all enables, mem_rd_o, bus_valid_o, the done flags and test_len_o are zero.
- R2: A start_i sampled high while no core is active sets every core's generator enable high for exactly its programmed pseudorandom length of consecutive cycles, beginning the cycle after the start edge. All cores run in parallel. A length of zero gives no enable cycles.
- R3: A core's stored-pattern phase begins only after its pseudorandom phase has ended, and it never begins earlier than one cycle after that end.
- R4: At most one core is in its stored-pattern phase at any time. The patterns of one core reach the bus as one uninterrupted run.
- R5: When the bus is free or being released, it goes to the lowest-indexed waiting core, which starts on the next edge. That core keeps the bus until its last pattern completes, and the next core may start in the cycle right after.
- R6: Pattern p of core k is read at address base_k + p. Reads for one core are spaced by its cycles-per-pattern value, and a value of 0 acts as 1. A core's phase lasts count × pacing cycles.
- R7: Each read is followed one cycle later by bus_valid_o, with bus_sel_o set to the owning core index and bus_data_o equal to the memory word at that address.
- R8: A core programmed with zero stored patterns sets its done flag on the edge its pseudorandom phase ends and never appears on the bus.
- R9: A core with stored patterns sets its done flag on the edge its last pattern cycle ends. Done flags stay set until the next accepted start.
- R10: all_done_o is high exactly when every core's done flag is set. test_len_o then holds the number of clock edges from the accepted start edge to the edge where the last done flag was set, and it stays frozen afterwards.
- R11: A start_i pulse while any core is still active has no effect on enables, bus traffic, done times or test_len_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new test |
| pr_len_i | input | N_CORES*PR_W | Per-core pseudorandom length, core k at bits k*PR_W |
| det_cnt_i | input | N_CORES*DET_W | Per-core stored-pattern count |
| cpp_i | input | N_CORES*CPP_W | Per-core cycles per stored pattern (0 acts as 1) |
| base_addr_i | input | N_CORES*ADDR_W | Per-core base address in pattern memory |
| prpg_en_o | output | N_CORES | Per-core pattern generator enable |
| mem_rd_o | output | 1 | Pattern memory read strobe |
| mem_addr_o | output | ADDR_W | Pattern memory address |
| mem_data_i | input | DATA_W | Memory word, valid one cycle after the read |
| bus_valid_o | output | 1 | Stored pattern valid on the shared test bus |
| bus_sel_o | output | SEL_W | Core index addressed by the bus |
| bus_data_o | output | DATA_W | Stored pattern on the bus |
| core_done_o | output | N_CORES | Per-core done flags |
| all_done_o | output | 1 | All cores done |
| test_len_o | output | CNT_W | Measured total test length in cycles |

## Verification
The bench builds four cores with a 10-bit length, a 6-bit pattern count, a 3-bit pacing field and a 10-bit address. With these widths, tie-breaking among several waiting cores, zero-length pseudorandom phases, zero pattern counts and the zero pacing value all occur within runs of a few hundred cycles. A bench-side scheduling model predicts each core's done edge, the exact cycle, address and owner of every bus transfer, and the total length. Random configurations are mixed with directed cases covering simultaneous waiting, an all-empty test of length zero and a start pulse in the middle of a run.

// File: rtl/hbist_pkg.sv
`timescale 1ns/1ps
package hbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PR,
    ST_WAIT,
    ST_DET,
    ST_DONE
  } core_st_e;
endpackage

// File: rtl/hbist_core_fsm.sv
`timescale 1ns/1ps
module hbist_core_fsm
  import hbist_pkg::*;
#(
  parameter int PR_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [PR_W-1:0] pr_len_i,
  input  logic            has_det_i,
  input  logic            grant_i,
  input  logic            last_i,
  output logic            prpg_en_o,
  output logic            req_o,
  output logic            det_o,
  output logic            busy_o,
  output logic            done_o
);
  core_st_e        st_q;
  logic [PR_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
    end else if (start_i) begin
      rem_q <= pr_len_i;
      if (pr_len_i != '0) st_q <= ST_PR;
      else                st_q <= has_det_i ? ST_WAIT : ST_DONE;
    end else begin
      unique case (st_q)
        ST_PR: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == PR_W'(1)) st_q <= has_det_i ? ST_WAIT : ST_DONE;
        end
        ST_WAIT: if (grant_i) st_q <= ST_DET;
        ST_DET:  if (last_i)  st_q <= ST_DONE;
        default: ;
      endcase
    end
  end

  assign prpg_en_o = (st_q == ST_PR);
  assign req_o     = (st_q == ST_WAIT);
  assign det_o     = (st_q == ST_DET);
  assign busy_o    = (st_q == ST_PR) || (st_q == ST_WAIT) || (st_q == ST_DET);
  assign done_o    = (st_q == ST_DONE);
endmodule

// File: rtl/hbist_arb.sv
`timescale 1ns/1ps
module hbist_arb #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic [N-1:0]     req_i,
  input  logic             free_i,
  output logic [N-1:0]     gnt_o,
  output logic [SEL_W-1:0] idx_o
);
  // descending scan: lowest requesting index is written last
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && free_i) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/hbist_det_dp.sv
`timescale 1ns/1ps
module hbist_det_dp #(
  parameter int DET_W  = 12,
  parameter int CPP_W  = 4,
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DET_W-1:0]  cnt_i,
  input  logic [CPP_W-1:0]  cpp_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              last_o
);
  logic              active_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] base_q;
  logic [DET_W-1:0]  cnt_q, pat_q;
  logic [CPP_W-1:0]  lim_q, cyc_q;
  logic              pat_end;

  assign pat_end = (cyc_q == lim_q);
  assign last_o  = active_q && pat_end && (pat_q == cnt_q - 1'b1);
  assign rd_o    = active_q && (cyc_q == '0);
  assign addr_o  = base_q + ADDR_W'(pat_q);
  assign sel_o   = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sel_q    <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      lim_q    <= '0;
      pat_q    <= '0;
      cyc_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      sel_q    <= sel_i;
      base_q   <= base_i;
      cnt_q    <= cnt_i;
      lim_q    <= (cpp_i == '0) ? '0 : cpp_i - 1'b1;
      pat_q    <= '0;
      cyc_q    <= '0;
    end else if (active_q) begin
      if (pat_end) begin
        cyc_q <= '0;
        pat_q <= pat_q + 1'b1;
        if (last_o) active_q <= 1'b0;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hbist_seq.sv
`timescale 1ns/1ps
module hbist_seq #(
  parameter int N_CORES = 4,
  parameter int PR_W    = 16,
  parameter int DET_W   = 12,
  parameter int CPP_W   = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 24,
  localparam int SEL_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [N_CORES*PR_W-1:0]   pr_len_i,
  input  logic [N_CORES*DET_W-1:0]  det_cnt_i,
  input  logic [N_CORES*CPP_W-1:0]  cpp_i,
  input  logic [N_CORES*ADDR_W-1:0] base_addr_i,
  output logic [N_CORES-1:0]        prpg_en_o,
  output logic                      mem_rd_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  input  logic [DATA_W-1:0]         mem_data_i,
  output logic                      bus_valid_o,
  output logic [SEL_W-1:0]          bus_sel_o,
  output logic [DATA_W-1:0]         bus_data_o,
  output logic [N_CORES-1:0]        core_done_o,
  output logic                      all_done_o,
  output logic [CNT_W-1:0]          test_len_o
);
  logic [N_CORES-1:0] req, gnt, det_st, busy;
  logic [SEL_W-1:0]   gnt_idx, dp_sel;
  logic               running, start_go, bus_free, det_last, load;
  logic               bus_valid_q;
  logic [SEL_W-1:0]   bus_sel_q;
  logic [CNT_W-1:0]   len_q;

  assign running  = |busy;
  assign start_go = start_i && !running;
  assign bus_free = !(|det_st) || det_last;
  assign load     = |gnt;

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    hbist_core_fsm #(.PR_W(PR_W)) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_go),
      .pr_len_i  (pr_len_i[k*PR_W +: PR_W]),
      .has_det_i (det_cnt_i[k*DET_W +: DET_W] != '0),
      .grant_i   (gnt[k]),
      .last_i    (det_last),
      .prpg_en_o (prpg_en_o[k]),
      .req_o     (req[k]),
      .det_o     (det_st[k]),
      .busy_o    (busy[k]),
      .done_o    (core_done_o[k])
    );
  end

  hbist_arb #(.N(N_CORES), .SEL_W(SEL_W)) u_arb (
    .req_i  (req),
    .free_i (bus_free),
    .gnt_o  (gnt),
    .idx_o  (gnt_idx)
  );

  hbist_det_dp #(
    .DET_W(DET_W), .CPP_W(CPP_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .sel_i  (gnt_idx),
    .base_i (base_addr_i[gnt_idx*ADDR_W +: ADDR_W]),
    .cnt_i  (det_cnt_i[gnt_idx*DET_W +: DET_W]),
    .cpp_i  (cpp_i[gnt_idx*CPP_W +: CPP_W]),
    .rd_o   (mem_rd_o),
    .addr_o (mem_addr_o),
    .sel_o  (dp_sel),
    .last_o (det_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_valid_q <= 1'b0;
      bus_sel_q   <= '0;
      len_q       <= '0;
    end else begin
      bus_valid_q <= mem_rd_o;
      if (mem_rd_o) bus_sel_q <= dp_sel;
      if (start_go)     len_q <= '0;
      else if (running) len_q <= len_q + 1'b1;
    end
  end

  assign bus_valid_o = bus_valid_q;
  assign bus_sel_o   = bus_sel_q;
  assign bus_data_o  = mem_data_i;
  assign all_done_o  = &core_done_o;
  assign test_len_o  = len_q;
endmodule

// File: rtl/hbist_seq_chk.sv
`timescale 1ns/1ps
module hbist_seq_chk #(
  parameter int N     = 4,
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [N-1:0]     det_st,
  input logic [N-1:0]     core_done_o,
  input logic             mem_rd_o,
  input logic             bus_valid_o,
  input logic             all_done_o,
  input logic [CNT_W-1:0] test_len_o
);
  // R4
  single_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(det_st));

  // R7
  rd_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> bus_valid_o);

  // R7
  valid_needs_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_o |=> !bus_valid_o);

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> ((~core_done_o & $past(core_done_o)) == '0));

  // R10
  len_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_done_o && !start_i) |=> $stable(test_len_o));
endmodule

bind hbist_seq hbist_seq_chk #(.N(N_CORES), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_hbist_seq.sv
`timescale 1ns/1ps
module sim_hbist_seq;
  localparam int NC = 4, PR_W = 10, DET_W = 6, CPP_W = 3, ADDR_W = 10;
  localparam int DATA_W = 16, CNT_W = 16, SEL_W = 2, MAXB = 512;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [NC*PR_W-1:0]   pr_len_i = '0;
  logic [NC*DET_W-1:0]  det_cnt_i = '0;
  logic [NC*CPP_W-1:0]  cpp_i = '0;
  logic [NC*ADDR_W-1:0] base_addr_i = '0;
  logic [NC-1:0]        prpg_en_o, core_done_o;
  logic                 mem_rd_o, bus_valid_o, all_done_o;
  logic [ADDR_W-1:0]    mem_addr_o;
  logic [DATA_W-1:0]    mem_data_i, bus_data_o;
  logic [SEL_W-1:0]     bus_sel_o;
  logic [CNT_W-1:0]     test_len_o;

  always #10 clk_i = ~clk_i;

  hbist_seq #(.N_CORES(NC), .PR_W(PR_W), .DET_W(DET_W), .CPP_W(CPP_W),
              .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (.*);

  function automatic logic [15:0] memf(input int a);
    logic [15:0] r;
    r = 16'(a % 1024) * 16'd37;
    return r ^ 16'h5A3C;
  endfunction

  always_ff @(posedge clk_i) mem_data_i <= memf(int'(mem_addr_o));

  int n_checks = 0, n_err = 0;
  int P[NC], D[NC], C[NC], B[NC];
  int exp_done[NC], exp_len;
  int ebt[MAXB], ebs[MAXB], ebd[MAXB], neb;
  int gbt[MAXB], gbs[MAXB], gbd[MAXB], ngb;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // schedule model built from R2..R9
  task automatic model();
    int cur, pick, st, ce;
    bit asg[NC];
    cur = 0; neb = 0; exp_len = 0;
    for (int k = 0; k < NC; k++) begin
      asg[k] = 0;
      exp_done[k] = P[k];
    end
    for (int r = 0; r < NC; r++) begin
      pick = -1;
      for (int k = 0; k < NC; k++)
        if (D[k] > 0 && !asg[k] && P[k] + 1 <= cur && pick < 0) pick = k;
      if (pick < 0) begin
        for (int k = 0; k < NC; k++)
          if (D[k] > 0 && !asg[k] && (pick < 0 || P[k] < P[pick])) pick = k;
        if (pick < 0) break;
        cur = P[pick] + 1;
      end
      asg[pick] = 1;
      st = cur;
      ce = (C[pick] == 0) ? 1 : C[pick];
      for (int p = 0; p < D[pick]; p++) begin
        ebt[neb] = st + p * ce + 1;
        ebs[neb] = pick;
        ebd[neb] = int'(memf(B[pick] + p));
        neb++;
      end
      cur = st + D[pick] * ce;
      exp_done[pick] = cur;
    end
    for (int k = 0; k < NC; k++) if (exp_done[k] > exp_len) exp_len = exp_done[k];
  endtask

  task automatic run_test(input string name, input int ign_at);
    int j, pcnt[NC], dt[NC], bad;
    for (int k = 0; k < NC; k++) begin
      pr_len_i[k*PR_W +: PR_W]      = PR_W'(P[k]);
      det_cnt_i[k*DET_W +: DET_W]   = DET_W'(D[k]);
      cpp_i[k*CPP_W +: CPP_W]       = CPP_W'(C[k]);
      base_addr_i[k*ADDR_W +: ADDR_W] = ADDR_W'(B[k]);
      pcnt[k] = 0;
      dt[k] = -1;
    end
    model();
    ngb = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    j = 0;
    while (1) begin
      for (int k = 0; k < NC; k++) begin
        if (prpg_en_o[k]) pcnt[k]++;
        if (core_done_o[k] && dt[k] < 0) dt[k] = j;
      end
      if (bus_valid_o && ngb < MAXB) begin
        gbt[ngb] = j; gbs[ngb] = int'(bus_sel_o); gbd[ngb] = int'(bus_data_o);
        ngb++;
      end
      if (all_done_o) break;
      if (j >= 4000) begin
        check(0, {name, " watchdog R10"}, j, exp_len);
        break;
      end
      start_i = (j == ign_at);
      @(negedge clk_i);
      j++;
    end
    start_i = 1'b0;
    for (int k = 0; k < NC; k++) begin
      check(pcnt[k] == P[k], {name, " R2 enable cycles"}, pcnt[k], P[k]);
      check(dt[k] == exp_done[k], {name, (D[k] == 0) ? " R8 done edge" : " R9 done edge"},
            dt[k], exp_done[k]);
    end
    check(j == exp_len, {name, " R10 all_done edge"}, j, exp_len);
    check(int'(test_len_o) == exp_len, {name, " R10 test_len"}, test_len_o, exp_len);
    check(ngb == neb, {name, " R6 transfer count"}, ngb, neb);
    bad = -1;
    for (int i = 0; i < neb && i < ngb; i++)
      if (bad < 0 && (gbt[i] != ebt[i] || gbs[i] != ebs[i] || gbd[i] != ebd[i])) bad = i;
    if (bad >= 0)
      check(0, {name, " R4 R5 R7 transfer (time/sel/data)"},
            longint'(gbt[bad]) * 1000000 + gbs[bad] * 100000 + gbd[bad],
            longint'(ebt[bad]) * 1000000 + ebs[bad] * 100000 + ebd[bad]);
    else
      check(1, {name, " R3 R5 R7 transfers"}, 0, 0);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(prpg_en_o == '0 && !mem_rd_o && !bus_valid_o, "R1 idle outputs in reset",
          {prpg_en_o, mem_rd_o, bus_valid_o}, 0);
    check(core_done_o == '0 && !all_done_o && test_len_o == '0, "R1 done/len in reset",
          {core_done_o, all_done_o, test_len_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(core_done_o == '0 && !all_done_o && prpg_en_o == '0, "R1 idle after release",
          {core_done_o, all_done_o, prpg_en_o}, 0);

    // tie between cores 1 and 2, zero pacing on core 0, zero patterns on core 3
    P = '{20, 5, 5, 30}; D = '{3, 2, 4, 0}; C = '{0, 1, 3, 2}; B = '{100, 200, 1020, 50};
    run_test("tie", -1);
    // all zero-length pseudorandom phases
    P = '{0, 0, 0, 0}; D = '{2, 1, 1, 3}; C = '{2, 3, 1, 1}; B = '{0, 10, 20, 30};
    run_test("pr_zero", -1);
    // empty test: length zero
    P = '{0, 0, 0, 0}; D = '{0, 0, 0, 0}; C = '{1, 1, 1, 1}; B = '{0, 0, 0, 0};
    run_test("empty", -1);
    // R11 start pulse mid-run ignored
    P = '{12, 40, 3, 25}; D = '{5, 2, 6, 1}; C = '{2, 4, 1, 7}; B = '{300, 400, 500, 600};
    run_test("ignore_start", 8);

    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < NC; k++) begin
        P[k] = $urandom_range(0, 40);
        D[k] = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 8);
        C[k] = $urandom_range(0, 4);
        B[k] = $urandom_range(0, 1023);
      end
      run_test($sformatf("rand%0d", t), -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #4000000;
    n_checks++;
    n_err++;
    $display("FAIL watchdog R10: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule